// File: doc/BRIEF.md
# SPI Clock Prescale Encoder

This block turns a wanted serial-clock rate into the 8-bit prescale code of a mantissa/exponent clock divider. The clock divider divides the core clock by `SPR * 2^SPPR`, where SPR is a 4-bit mantissa and SPPR is a 3-bit exponent. The encoder picks the code that gives the fastest serial clock that is still no faster than the request. The divider that is needed can come from two places. In one mode it is computed as the ceiling of core frequency over requested rate. In the other mode an integer divider is applied directly.

A request is one cycle of `start` while the block is idle. In divide mode a restoring divider runs one quotient bit per cycle. The mantissa/exponent search then happens in one combinational stage, and the result is registered and announced by a single-cycle `done`. A request that would need more division than the code can express sets `err`. A zero requested rate also sets `err`.

Top module: `spi_psc_top`

## Requirements
- R1: In divide mode (`direct`=0, `rate_hz`≠0) the divider used is ceil(`core_hz` / `rate_hz`).
- R2: A divider D below 16 yields `spr`=D, `sppr`=0 and `err`=0.
- R3: A divider D of 16 or more yields the smallest exponent E for which ceil(D / 2^E) ≤ 15. In that case `spr` = ceil(D / 2^E), `sppr` = E, and `spr` bit 3 is set whenever `sppr` is nonzero. The product `spr`·2^`sppr` is therefore never below D.
- R4: If the exponent that R3 requires exceeds 7 (any divider above 1920), `err` is 1 and `spr`, `sppr` and `field` are all 0.
- R5: A divide-mode request with `rate_hz`=0 sets `err`=1 with zero `spr`, `sppr` and `field`.
- R6: When `err` is 0, `field` bits 3:0 hold `spr`, bit 4 holds `sppr[0]`, bit 5 is 0, and bits 7:6 hold `sppr[2:1]`.
- R7: In direct mode (`direct`=1) the divider used is `div_in` and `core_hz`/`rate_hz` are not used.
- R8: `done` is a one-cycle pulse with `busy` low. Counting the edge that samples `start` as the first, `done` appears after 2 rising edges for direct mode and for zero-rate requests, and after W+2 edges for divide mode.
- R9: A `start` while `busy` is high is ignored. The result and the timing of `done` belong to the accepted request, and no extra `done` follows.
- R10: `err`, `spr`, `sppr` and `field` change only in the cycle where `done` is high and otherwise hold their last values.
- R11: After reset `busy`, `done` and `err` are 0 and `spr`, `sppr` and `field` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| direct | input | 1 | 1: use `div_in`; 0: divide `core_hz` by `rate_hz` |
| core_hz | input | W | Core clock frequency |
| rate_hz | input | W | Requested serial clock rate |
| div_in | input | W | Integer divider for direct mode |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request not encodable, or zero rate |
| spr | output | 4 | Mantissa of the divider |
| sppr | output | 3 | Exponent of the divider |
| field | output | 8 | Packed prescale code |

## Verification
Direct-mode and zero-rate requests deliver `done` after the second rising edge, counting the edge that samples `start`. Divide-mode requests take W+2 edges, because the restoring divider spends W cycles and the encode and register stage adds one more. The bench drives `start` on a falling edge and checks `done` and the outputs only on the following falling edges. It counts edges until `done` is seen and compares that count with the expected latency for the mode. It checks the held outputs several falling edges after `done`, and checks again after a `start` issued mid-division. In both cases it confirms that no second `done` appears.

// File: rtl/spi_psc_pkg.sv
package spi_psc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } psc_state_e;

  typedef struct packed {
    logic [3:0] spr;
    logic [2:0] sppr;
    logic       err;
  } psc_code_t;

  // 1-based index of the highest set bit, 0 for a zero value
  function automatic int fls1(input logic [63:0] v);
    int r;
    r = 0;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) r = i + 1;
    end
    return r;
  endfunction

  // mantissa in 3:0, exponent bit 0 in 4, exponent bits 2:1 in 7:6
  function automatic logic [7:0] pack_field(input logic [3:0] m, input logic [2:0] e);
    return {e[2:1], 1'b0, e[0], m};
  endfunction

endpackage

// File: rtl/spi_psc_div.sv
module spi_psc_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0] acc_q;
  logic [W-1:0] rem_q;
  logic [W-1:0] dvs_q;
  logic [W:0]   shifted;
  logic         fits;

  assign shifted = {rem_q, acc_q[W-1]};
  assign fits    = (shifted >= {1'b0, dvs_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      acc_q <= dividend;
      rem_q <= '0;
      dvs_q <= divisor;
    end else if (step) begin
      if (fits) begin
        rem_q <= W'(shifted - {1'b0, dvs_q});
        acc_q <= {acc_q[W-2:0], 1'b1};
      end else begin
        rem_q <= shifted[W-1:0];
        acc_q <= {acc_q[W-2:0], 1'b0};
      end
    end
  end

  assign quo = acc_q;
  assign rem = rem_q;
endmodule

// File: rtl/spi_psc_enc.sv
module spi_psc_enc
  import spi_psc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] div_i,
  output psc_code_t    code
);
  logic [W:0] wide;
  logic [W:0] one;
  logic [W:0] msk;
  logic [W:0] rnd;
  int         lead;
  int         lead2;

  assign one = (W+1)'(1);

  always_comb begin
    wide  = {1'b0, div_i};
    msk   = '0;
    rnd   = wide;
    lead  = 0;
    lead2 = 0;
    code  = '0;
    if (div_i < W'(16)) begin
      code.spr = div_i[3:0];
    end else begin
      lead  = fls1(64'(wide)) - 4;
      msk   = (one << lead) - one;
      rnd   = (wide + msk) & ~msk;
      lead2 = fls1(64'(rnd)) - 4;
      if (lead2 > 7) begin
        code.err = 1'b1;
      end else begin
        code.spr  = 4'(rnd >> lead2);
        code.sppr = 3'(lead2);
      end
    end
  end
endmodule

// File: rtl/spi_psc_top.sv
module spi_psc_top
  import spi_psc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         direct,
  input  logic [W-1:0] core_hz,
  input  logic [W-1:0] rate_hz,
  input  logic [W-1:0] div_in,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [3:0]   spr,
  output logic [2:0]   sppr,
  output logic [7:0]   field
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  psc_state_e   state;
  logic [CW-1:0] cnt;
  logic [W-1:0] held_div;
  logic         use_quot;
  logic         zero_rate;
  logic [W-1:0] quo;
  logic [W-1:0] rem;
  logic [W-1:0] enc_in;
  psc_code_t    enc_code;

  // named events
  logic accept;
  logic needs_div;
  logic div_last;
  logic fin_evt;

  assign accept    = start && (state == ST_IDLE);
  assign needs_div = !direct && (rate_hz != '0);
  assign div_last  = (state == ST_DIV) && (cnt == CW'(W-1));
  assign fin_evt   = (state == ST_FIN);

  spi_psc_div #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (state == ST_DIV),
    .dividend (core_hz),
    .divisor  (rate_hz),
    .quo      (quo),
    .rem      (rem)
  );

  assign enc_in = use_quot ? (quo + W'(rem != '0)) : held_div;

  spi_psc_enc #(.W(W)) u_enc (
    .div_i (enc_in),
    .code  (enc_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      held_div  <= '0;
      use_quot  <= 1'b0;
      zero_rate <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          held_div  <= div_in;
          use_quot  <= needs_div;
          zero_rate <= !direct && (rate_hz == '0);
          cnt       <= '0;
          state     <= needs_div ? ST_DIV : ST_FIN;
        end
        ST_DIV: begin
          cnt <= cnt + 1'b1;
          if (div_last) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      err   <= 1'b0;
      spr   <= '0;
      sppr  <= '0;
      field <= '0;
    end else begin
      done <= fin_evt;
      if (fin_evt) begin
        if (zero_rate || enc_code.err) begin
          err   <= 1'b1;
          spr   <= '0;
          sppr  <= '0;
          field <= '0;
        end else begin
          err   <= 1'b0;
          spr   <= enc_code.spr;
          sppr  <= enc_code.sppr;
          field <= pack_field(enc_code.spr, enc_code.sppr);
        end
      end
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/spi_psc_chk.sv
module spi_psc_chk #(
  parameter int W = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       accept,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [3:0] spr,
  input logic [2:0] sppr,
  input logic [7:0] field
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R9
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R9
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(field) && $stable(err) && $stable(spr) && $stable(sppr))); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (field == 8'd0 && spr == 4'd0 && sppr == 3'd0)); // R4
  AST_FIELD_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !err |-> (field == {sppr[2:1], 1'b0, sppr[0], spr})); // R6
  AST_MANT_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (!err && sppr != 3'd0) |-> spr[3]); // R3
endmodule

bind spi_psc_top spi_psc_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .accept (accept),
  .busy   (busy),
  .done   (done),
  .err    (err),
  .spr    (spr),
  .sppr   (sppr),
  .field  (field)
);

// File: tb/sim_spi_psc_top.sv
module sim_spi_psc_top;
  localparam int W = 32;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         direct = 1'b0;
  logic [W-1:0] core_hz = '0;
  logic [W-1:0] rate_hz = '0;
  logic [W-1:0] div_in = '0;
  logic         busy, done, err;
  logic [3:0]   spr;
  logic [2:0]   sppr;
  logic [7:0]   field;

  int n_chk = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  spi_psc_top #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .direct(direct),
    .core_hz(core_hz), .rate_hz(rate_hz), .div_in(div_in),
    .busy(busy), .done(done), .err(err), .spr(spr), .sppr(sppr), .field(field)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // smallest exponent whose 4-bit mantissa reaches d
  task automatic ref_enc(input longint d, output int m, output int e, output bit er);
    longint mm;
    int ee;
    mm = d;
    for (ee = 0; ee < 62; ee++) begin
      mm = (d + (64'sd1 <<< ee) - 1) >>> ee;
      if (mm <= 15) break;
    end
    er = (ee > 7);
    m  = er ? 0 : int'(mm);
    e  = er ? 0 : ee;
  endtask

  function automatic int ref_field(input int m, input int e);
    return ((e / 2) * 64) + ((e % 2) * 16) + m;
  endfunction

  task automatic issue(input bit dir, input longint c, input longint r, input longint d, output int lat);
    @(negedge clk);
    direct  = dir;
    core_hz = W'(c);
    rate_hz = W'(r);
    div_in  = W'(d);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_case(input bit dir, input longint c, input longint r, input longint d, input string req);
    int lat, m, e, exp_lat;
    bit er;
    longint dv;
    issue(dir, c, r, d, lat);
    if (dir) dv = d;
    else if (r != 0) dv = (c + r - 1) / r;
    else dv = 0;
    ref_enc(dv, m, e, er);
    if (!dir && r == 0) begin er = 1; m = 0; e = 0; end
    exp_lat = (dir || r == 0) ? 2 : W + 2;
    chk(lat == exp_lat, "R8 latency", lat, exp_lat);
    chk(err == er, req, err, er);
    chk(spr == 4'(m) && sppr == 3'(e), req, {sppr, spr}, (e * 16) + m);
    chk(field == 8'(er ? 0 : ref_field(m, e)), "R6 field", field, er ? 0 : ref_field(m, e));
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, m, e;
    bit er;
    logic [7:0] f0;
    bit extra;
    logic [3:0] s0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !err, "R11 flags", {busy, done, err}, 0);
    chk(spr == 0 && sppr == 0 && field == 0, "R11 code", field, 0);
    rst_n = 1'b1;

    // R2/R3/R4/R7: exhaustive direct sweep across the encodable edge
    for (int d = 0; d <= 2100; d++) begin
      run_case(1'b1, 64'd12345, 64'd0, d, d < 16 ? "R2 small" : (d <= 1920 ? "R3 round" : "R4 range"));
    end
    run_case(1'b1, 0, 0, 64'hFFFF_FFFF, "R4 max");
    run_case(1'b1, 0, 0, 64'h0001_0000, "R4 large");

    // R1: divide mode over several core rates
    for (int ci = 0; ci < 5; ci++) begin
      longint cr;
      cr = (ci == 0) ? 100 : (ci == 1) ? 1000 : (ci == 2) ? 200000 : (ci == 3) ? 250000000 : 64'hFFFF_FFFF;
      for (int r = 1; r <= 40; r++) run_case(1'b0, cr, r * r * 7 + r, 0, "R1 ceil");
      run_case(1'b0, cr, 1, 0, "R1 unit");
      run_case(1'b0, cr, 64'hFFFF_FFFF, 0, "R1 slow");
    end
    run_case(1'b0, 250000000, 50000000, 0, "R1 exact");
    run_case(1'b0, 200000000, 1000000, 0, "R1 mid");

    // R5 zero rate
    run_case(1'b0, 1000, 0, 0, "R5 zero rate");

    // R7: direct mode ignores core/rate (zero rate would otherwise error)
    run_case(1'b1, 5, 0, 9, "R7 direct");

    // R10: outputs hold after done
    run_case(1'b1, 0, 0, 300, "R3 hold setup");
    f0 = field;
    s0 = spr;
    repeat (5) @(negedge clk);
    chk(field == f0 && spr == s0, "R10 hold", field, f0);

    // R9: start while busy is ignored
    @(negedge clk);
    direct = 1'b0; core_hz = 1000; rate_hz = 3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    direct = 1'b1; div_in = 5000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 5;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == W + 2, "R9 latency", lat, W + 2);
    ref_enc(334, m, e, er);
    chk(spr == 4'(m) && sppr == 3'(e) && !err, "R9 result", {sppr, spr}, (e * 16) + m);
    extra = 1'b0;
    for (int k = 0; k < W + 5; k++) begin
      @(negedge clk);
      if (done) extra = 1'b1;
    end
    chk(!extra, "R9 no extra done", extra, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule